// File: doc/BRIEF.md
# Three-Class Memory Request Arbiter

This block sits in front of a single memory controller port and decides which of many requesters gets to issue the next transaction. Every requester carries a class that software can change at any time. The classes are low-jitter, jitter-tolerant, best effort and off.

Low-jitter requesters are served from a programmable time-division slot table, which bounds their worst-case wait. Jitter-tolerant requesters compete by a programmable priority, which secures them a share of bandwidth. Best-effort requesters share what is left in round-robin order. The three tiers are consulted strictly in that order on every decision. A slot whose owner is idle is skipped, and that decision falls through to the lower tiers.

Exactly one transaction is offered at a time on a valid/ready output. The offer stays fixed until it is accepted. After an acceptance there is one decision cycle before the next offer. Configuration writes land in the tables at once. They are only read when a decision is made, so a transaction that is already on offer is never disturbed.

Top module: `memq_class_arb`

## Requirements
- R1: After reset the output offers nothing. Every requester is best effort (class code 0) with priority 0. All slot entries name requester 0, the table length is 1, and the slot and round-robin pointers are 0.
- R2: While `outVld` is high and `outRdy` is low, `outVld` stays high and `outIdx` stays unchanged. In the cycle after an acceptance (`outVld` and `outRdy` both high), `outVld` is low.
- R3: A decision is made in every cycle in which `outVld` is low. An offer is only made for a requester whose `reqVld` bit was high in the decision cycle. With no eligible request, nothing is offered.
- R4: If the slot entry at the current pointer names a requester of class low-jitter (code 2) that is requesting, that requester wins over every other requester, whatever their class or priority.
- R5: If the current slot's owner is not requesting, or is not low-jitter, the slot is skipped and the decision falls through to the jitter-tolerant and best-effort tiers.
- R6: The slot pointer advances by one on every decision cycle, whether or not a grant results. It wraps to 0 after the entry at index length-1. A pointer beyond the length is treated as 0.
- R7: Among requesting jitter-tolerant requesters (code 1), the highest priority value wins, and equal priorities go to the lowest index. Any jitter-tolerant request beats every best-effort request.
- R8: Best-effort requesters (code 0) are searched upward from the round-robin pointer, wrapping at the last index. The pointer moves to one past the winner only when a best-effort requester is granted.
- R9: A requester of class off (code 3) is never granted. A low-jitter requester is granted only through a slot it owns.
- R10: Configuration writes use `cfgSel`:
  - 0 writes the class of requester `cfgAddr` from data bits [1:0]; addresses of `NUM_REQ` or more are ignored.
  - 1 writes its priority from bits [PRIO_W-1:0].
  - 2 writes the owner of slot `cfgAddr` from bits [IDX_W-1:0].
  - 3 writes length-1 from bits [SLOT_W-1:0].

  A write during an offer leaves `outIdx` unchanged and is used from the next decision on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqVld | input | NUM_REQ | One request line per requester, level sensitive |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Configuration target: 0 class, 1 priority, 2 slot entry, 3 table length-1 |
| cfgAddr | input | ADDR_W | Requester or slot index of the write |
| cfgData | input | CFG_W | Write data |
| outVld | output | 1 | A transaction is offered to the memory controller |
| outIdx | output | IDX_W | Index of the requester being offered |
| outRdy | input | 1 | Memory controller accepts the offer |

## Verification
The bench targets the following corner cases, and how a faulty design would show up:

- **Equal jitter-tolerant priorities.** A design that scans in the wrong direction hands the grant to the higher index.
- **A jitter-tolerant grant between best-effort grants.** A round-robin pointer that moves on every grant skips a best-effort requester that should have been next.
- **A slot owner that is absent, or a low-jitter requester that is not the current owner.** A design that does not skip the slot stalls the decision. A design that lets non-owners through grants the wrong low-jitter requester.
- **Reclassification during a held offer.** A design that reads live configuration into the offer changes `outIdx` mid-transaction. A design that caches configuration too long grants a requester that was just switched off.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    CLS_BEST = 2'd0,
    CLS_TOL  = 2'd1,
    CLS_LOWJ = 2'd2,
    CLS_OFF  = 2'd3
  } reqClass_t;

  typedef enum logic [1:0] {
    SEL_CLASS = 2'd0,
    SEL_PRIO  = 2'd1,
    SEL_SLOT  = 2'd2,
    SEL_LEN   = 2'd3
  } cfgSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic decide;   // no offer pending: evaluate the tiers this cycle
    logic retire;   // current offer accepted this cycle
  } arbStrobe_t;

endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       outRdy,
  input  logic       found,
  output arbStrobe_t strb,
  output logic       busy
);

  always_comb begin
    strb.decide = !busy;
    strb.retire = busy && outRdy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
    end else if (strb.decide && found) begin
      busy <= 1'b1;
    end else if (strb.retire) begin
      busy <= 1'b0;
    end
  end

endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int NUM_REQ    = 8,
  parameter int SLOT_DEPTH = 16,
  parameter int PRIO_W     = 3,
  parameter int IDX_W      = 3,
  parameter int SLOT_W     = 4,
  parameter int ADDR_W     = 4,
  parameter int CFG_W      = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqVld,
  input  logic               cfgWe,
  input  logic [1:0]         cfgSel,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [CFG_W-1:0]   cfgData,
  input  arbStrobe_t         strb,
  output logic               found,
  output logic [IDX_W-1:0]   outIdx
);

  localparam logic [ADDR_W:0]  NREQ_L   = (ADDR_W+1)'(NUM_REQ);
  localparam logic [IDX_W-1:0] LAST_REQ = IDX_W'(NUM_REQ - 1);

  reqClass_t         classTab [NUM_REQ];
  logic [PRIO_W-1:0] prioTab  [NUM_REQ];
  logic [IDX_W-1:0]  slotTab  [SLOT_DEPTH];
  logic [SLOT_W-1:0] lenM1;
  logic [SLOT_W-1:0] slotPtr;
  logic [IDX_W-1:0]  rrPtr;
  logic [IDX_W-1:0]  grantIdx;

  // ---------------- configuration tables ----------------
  logic addrIsReq;
  assign addrIsReq = {1'b0, cfgAddr} < NREQ_L;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REQ; i++) begin
        classTab[i] <= CLS_BEST;
        prioTab[i]  <= '0;
      end
      for (int s = 0; s < SLOT_DEPTH; s++) slotTab[s] <= '0;
      lenM1 <= '0;
    end else if (cfgWe) begin
      case (cfgSel_t'(cfgSel))
        SEL_CLASS: if (addrIsReq) classTab[cfgAddr[IDX_W-1:0]] <= reqClass_t'(cfgData[1:0]);
        SEL_PRIO:  if (addrIsReq) prioTab[cfgAddr[IDX_W-1:0]] <= cfgData[PRIO_W-1:0];
        SEL_SLOT:  slotTab[cfgAddr[SLOT_W-1:0]] <= cfgData[IDX_W-1:0];
        default:   lenM1 <= cfgData[SLOT_W-1:0];
      endcase
    end
  end

  // ---------------- per-requester tier membership ----------------
  logic [NUM_REQ-1:0] tolReq, beReq;
  for (genvar g = 0; g < NUM_REQ; g++) begin : g_member
    assign tolReq[g] = reqVld[g] && (classTab[g] == CLS_TOL);
    assign beReq[g]  = reqVld[g] && (classTab[g] == CLS_BEST);
  end

  // ---------------- slot tier ----------------
  logic [SLOT_W-1:0] effPtr, nextPtr;
  logic [IDX_W-1:0]  owner;
  logic              slotHit;
  always_comb begin
    effPtr  = (slotPtr > lenM1) ? '0 : slotPtr;
    nextPtr = (effPtr == lenM1) ? '0 : effPtr + SLOT_W'(1);
    owner   = slotTab[effPtr];
    slotHit = reqVld[owner] && (classTab[owner] == CLS_LOWJ);
  end

  // ---------------- priority tier ----------------
  logic              tolHit;
  logic [IDX_W-1:0]  tolIdx;
  logic [PRIO_W-1:0] tolBest;
  always_comb begin
    tolHit  = 1'b0;
    tolIdx  = '0;
    tolBest = '0;
    // scanning downward with >= leaves the lowest index on a tie
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (tolReq[i] && (!tolHit || prioTab[i] >= tolBest)) begin
        tolHit  = 1'b1;
        tolIdx  = IDX_W'(i);
        tolBest = prioTab[i];
      end
    end
  end

  // ---------------- round-robin tier ----------------
  logic             beHit;
  logic [IDX_W-1:0] beIdx;
  int               probe;
  always_comb begin
    beHit = 1'b0;
    beIdx = '0;
    probe = 0;
    for (int k = 0; k < NUM_REQ; k++) begin
      probe = int'(rrPtr) + k;
      if (probe >= NUM_REQ) probe = probe - NUM_REQ;
      if (!beHit && beReq[probe]) begin
        beHit = 1'b1;
        beIdx = IDX_W'(probe);
      end
    end
  end

  // ---------------- tier order and state update ----------------
  logic [IDX_W-1:0] winIdx;
  logic             winBe;
  always_comb begin
    found  = slotHit || tolHit || beHit;
    winBe  = !slotHit && !tolHit && beHit;
    winIdx = slotHit ? owner : (tolHit ? tolIdx : beIdx);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotPtr  <= '0;
      rrPtr    <= '0;
      grantIdx <= '0;
    end else if (strb.decide) begin
      slotPtr <= nextPtr;
      if (found) grantIdx <= winIdx;
      if (winBe) rrPtr <= (beIdx == LAST_REQ) ? '0 : beIdx + IDX_W'(1);
    end
  end

  assign outIdx = grantIdx;

endmodule

// File: rtl/memq_class_arb.sv
module memq_class_arb
  import arb_pkg::*;
#(
  parameter int NUM_REQ    = 8,
  parameter int SLOT_DEPTH = 16,
  parameter int PRIO_W     = 3,
  localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int SLOT_W = (SLOT_DEPTH > 1) ? $clog2(SLOT_DEPTH) : 1,
  localparam int ADDR_W = (IDX_W > SLOT_W) ? IDX_W : SLOT_W,
  localparam int CFG_A  = (IDX_W > PRIO_W) ? IDX_W : PRIO_W,
  localparam int CFG_B  = (SLOT_W > 2) ? SLOT_W : 2,
  localparam int CFG_W  = (CFG_A > CFG_B) ? CFG_A : CFG_B
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqVld,
  input  logic               cfgWe,
  input  logic [1:0]         cfgSel,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [CFG_W-1:0]   cfgData,
  output logic               outVld,
  output logic [IDX_W-1:0]   outIdx,
  input  logic               outRdy
);

  arbStrobe_t strb;
  logic       found;
  logic       busy;

  arb_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .outRdy (outRdy),
    .found  (found),
    .strb   (strb),
    .busy   (busy)
  );

  arb_datapath #(
    .NUM_REQ    (NUM_REQ),
    .SLOT_DEPTH (SLOT_DEPTH),
    .PRIO_W     (PRIO_W),
    .IDX_W      (IDX_W),
    .SLOT_W     (SLOT_W),
    .ADDR_W     (ADDR_W),
    .CFG_W      (CFG_W)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .reqVld  (reqVld),
    .cfgWe   (cfgWe),
    .cfgSel  (cfgSel),
    .cfgAddr (cfgAddr),
    .cfgData (cfgData),
    .strb    (strb),
    .found   (found),
    .outIdx  (outIdx)
  );

  assign outVld = busy;

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int NUM_REQ = 8,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_REQ-1:0] reqVld,
  input logic               outVld,
  input logic [IDX_W-1:0]   outIdx,
  input logic               outRdy
);

  logic [NUM_REQ-1:0] prevReq;
  always_ff @(posedge clk) begin
    if (!rstN) prevReq <= '0;
    else       prevReq <= reqVld;
  end

  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rstN)
    outVld && !outRdy |=> outVld && $stable(outIdx)); // R2

  AST_GAP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    outVld && outRdy |=> !outVld); // R2

  AST_DROP_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outVld) |-> $past(outRdy)); // R2

  AST_GRANT_WAS_REQUESTED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outVld) |-> prevReq[outIdx]); // R3

  AST_IDLE_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !outVld && (reqVld == '0) |=> !outVld); // R3

endmodule

bind memq_class_arb arb_checker #(
  .NUM_REQ (NUM_REQ),
  .IDX_W   (IDX_W)
) i_arb_checker (
  .clk    (clk),
  .rstN   (rstN),
  .reqVld (reqVld),
  .outVld (outVld),
  .outIdx (outIdx),
  .outRdy (outRdy)
);

// File: tb/test_memq_class_arb.sv
module test_memq_class_arb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] reqVld;
  logic       cfgWe;
  logic [1:0] cfgSel;
  logic [3:0] cfgAddr;
  logic [3:0] cfgData;
  logic       outVld;
  logic [2:0] outIdx;
  logic       outRdy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memq_class_arb i_memq_class_arb (
    .clk     (clk),
    .rstN    (rstN),
    .reqVld  (reqVld),
    .cfgWe   (cfgWe),
    .cfgSel  (cfgSel),
    .cfgAddr (cfgAddr),
    .cfgData (cfgData),
    .outVld  (outVld),
    .outIdx  (outIdx),
    .outRdy  (outRdy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rstN = 1'b0; reqVld = '0; cfgWe = 1'b0; cfgSel = '0;
    cfgAddr = '0; cfgData = '0; outRdy = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [3:0] addr, input logic [3:0] data);
    cfgWe = 1'b1; cfgSel = sel; cfgAddr = addr; cfgData = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // waits for an offer and compares its index; does not accept it
  task automatic expect_grant(input int exp, input string tag);
    bit got = 1'b0;
    for (int n = 0; n < 10; n++) begin
      @(negedge clk);
      if (outVld) begin got = 1'b1; break; end
    end
    check(got && (outIdx == exp), tag, got ? int'(outIdx) : -1, exp);
  endtask

  task automatic accept(input string tag);
    outRdy = 1'b1;
    @(negedge clk);
    outRdy = 1'b0;
    check(!outVld, tag, int'(outVld), 0);
  endtask

  task automatic t_reset();
    do_reset();
    check(!outVld, "R1 no offer after reset", int'(outVld), 0);
    reqVld = 8'b0000_0011;
    expect_grant(0, "R1 default best effort from pointer 0");
    accept("R2 gap after accept");
    expect_grant(1, "R8 round robin moves on");
    reqVld = '0;
    accept("R2 gap after accept");
  endtask

  task automatic t_idle();
    bit quiet = 1'b1;
    do_reset();
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      if (outVld) quiet = 1'b0;
    end
    check(quiet, "R3 no request no offer", int'(!quiet), 0);
  endtask

  task automatic t_handshake();
    bit steady = 1'b1;
    do_reset();
    reqVld = 8'b0001_0000;
    expect_grant(4, "R3 single requester");
    // reconfigure while the offer is held
    cfg_write(2'd0, 4'd4, 4'd3);
    cfg_write(2'd0, 4'd2, 4'd1);
    reqVld = 8'b0001_0100;
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      if (!outVld || outIdx != 3'd4) steady = 1'b0;
    end
    check(steady, "R2 offer held while not ready", int'(outIdx), 4);
    check(outIdx == 3'd4, "R10 write mid-offer leaves index", int'(outIdx), 4);
    accept("R2 gap after accept");
    expect_grant(2, "R10 new class used at next decision");
    reqVld = 8'b0001_0000;
    accept("R2 gap after accept");
    steady = 1'b1;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      if (outVld) steady = 1'b0;
    end
    check(steady, "R9 class off never granted", int'(outVld), 0);
    reqVld = '0;
  endtask

  task automatic t_prio();
    do_reset();
    cfg_write(2'd0, 4'd1, 4'd1); cfg_write(2'd1, 4'd1, 4'd2);
    cfg_write(2'd0, 4'd4, 4'd1); cfg_write(2'd1, 4'd4, 4'd5);
    cfg_write(2'd0, 4'd6, 4'd1); cfg_write(2'd1, 4'd6, 4'd5);
    reqVld = 8'b0101_0011;
    expect_grant(4, "R7 tie goes to lowest index");
    reqVld = 8'b0100_0011;
    accept("R2 gap after accept");
    expect_grant(6, "R7 highest priority");
    reqVld = 8'b0000_0011;
    accept("R2 gap after accept");
    expect_grant(1, "R7 tolerant beats best effort");
    reqVld = 8'b0000_0001;
    accept("R2 gap after accept");
    expect_grant(0, "R7 best effort last");
    reqVld = '0;
    accept("R2 gap after accept");
  endtask

  task automatic t_rr();
    do_reset();
    reqVld = 8'b0100_1010;
    expect_grant(1, "R8 first from pointer 0");
    accept("R2 gap after accept");
    expect_grant(3, "R8 next upward");
    accept("R2 gap after accept");
    expect_grant(6, "R8 next upward");
    accept("R2 gap after accept");
    expect_grant(1, "R8 wraps");
    // pointer now 2; a tolerant grant must not move it
    cfg_write(2'd0, 4'd5, 4'd1);
    reqVld = 8'b0110_1000;
    accept("R2 gap after accept");
    expect_grant(5, "R8 tolerant tier first");
    reqVld = 8'b0100_1000;
    accept("R2 gap after accept");
    expect_grant(3, "R8 pointer held over tolerant grant");
    reqVld = '0;
    accept("R2 gap after accept");
  endtask

  task automatic t_slot_wrap();
    do_reset();
    cfg_write(2'd0, 4'd2, 4'd2); cfg_write(2'd0, 4'd3, 4'd2);
    cfg_write(2'd2, 4'd0, 4'd2); cfg_write(2'd2, 4'd1, 4'd3);
    cfg_write(2'd0, 4'd6, 4'd1); cfg_write(2'd1, 4'd6, 4'd7);
    cfg_write(2'd3, 4'd0, 4'd1);
    reqVld = 8'b0100_1100;
    expect_grant(2, "R4 slot owner beats priority");
    accept("R2 gap after accept");
    expect_grant(3, "R6 pointer advanced");
    accept("R2 gap after accept");
    expect_grant(2, "R6 pointer wrapped at length");
    accept("R2 gap after accept");
    expect_grant(3, "R4 slot owner again");
    reqVld = '0;
    accept("R2 gap after accept");
  endtask

  task automatic t_slot_skip();
    do_reset();
    cfg_write(2'd0, 4'd2, 4'd2); cfg_write(2'd0, 4'd3, 4'd2);
    cfg_write(2'd2, 4'd0, 4'd2); cfg_write(2'd2, 4'd1, 4'd3);
    cfg_write(2'd3, 4'd0, 4'd1);
    reqVld = 8'b0010_1000;
    expect_grant(5, "R5 absent owner skipped, R9 non-owner excluded");
    accept("R2 gap after accept");
    expect_grant(3, "R4 owner of next slot");
    accept("R2 gap after accept");
    expect_grant(5, "R5 skip again");
    reqVld = '0;
    accept("R2 gap after accept");
  endtask

  initial begin
    t_reset();
    t_idle();
    t_handshake();
    t_prio();
    t_rr();
    t_slot_wrap();
    t_slot_skip();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule